// File: doc/BRIEF.md
# Way-Predicted Two-Way Read Cache

This block is a two-way set-associative read cache that gets close to direct-mapped hit latency. Each set holds a one-bit guess of which way will hit next. When a request is looked up, the guess selects the output data word before any tag result is known. Only the guessed way's tag is compared in that first cycle. If that comparison fails, the other way is compared in the next cycle. A match there is still a hit, one cycle slower, and the guess for that set is retrained.

When neither way matches, the block asks the memory side for the whole block. It writes the returned words into the least-recently-used way of the set and then answers the request. Every response carries a kind code: fast hit, slow hit or miss. A processor or a testbench can use that code to measure how often the guess is right.

The processor side accepts one request at a time through a valid/ready handshake. The memory side issues a single-cycle request pulse with a block address and accepts one word per beat.

Top module: `wp_cache`

## Requirements
- R1: The address is split into a word offset in the low $clog2(WORDS) bits, a set index in the next $clog2(SETS) bits, and a tag in the remaining upper bits. After reset every line is invalid and every set predicts way 0, so the first access to any address is a miss. Out of reset, req_ready is 1 and both rsp_valid and mem_req_valid are 0.
- R2: When the predicted way holds the tag, rsp_valid is high in the cycle right after the accept cycle, with rsp_kind = 1 (fast hit).
- R3: When only the other way holds the tag, rsp_valid is high two cycles after the accept cycle, with rsp_kind = 2 (slow hit). The set's prediction then names that way, so an immediate repeat of the access is a fast hit.
- R4: When neither way holds the tag, exactly one mem_req_valid pulse is issued, carrying the request address with its offset bits cleared. WORDS beats are then accepted, word 0 first. The response has rsp_kind = 3 (miss) and returns the requested word of the refilled block.
- R5: A refill goes into the least-recently-used way of its set, and the set's prediction is set to that way. Any hit or refill makes the other way of the set the least recently used.
- R6: req_ready is high only while no request is in progress. It is low from the cycle after acceptance until the cycle after the response. Each accepted request gets exactly one single-cycle rsp_valid pulse.
- R7: rsp_data on every fast or slow hit equals the word last refilled for that address.
- R8: mem_req_valid is a one-cycle pulse, raised only for a request that missed in both ways. rsp_kind is 0 whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_data | output | DATA_W | Read data |
| rsp_kind | output | 2 | 0 none, 1 fast hit, 2 slow hit, 3 miss |
| mem_req_valid | output | 1 | Block refill request pulse |
| mem_req_addr | output | ADDR_W | Block-aligned refill address |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_data | input | DATA_W | Refill word, word 0 first |

## Verification
The assertions assume the memory side answers a refill request only after the pulse, with exactly WORDS beats, and never sends beats while no refill is pending. They also assume req_valid is driven low during reset, so the one-cycle look-back checks start from clean history. The bench's memory model waits two cycles after each pulse and then streams the block words back to back. It never raises a beat outside that window. Processor requests are presented only while req_ready is high and are withdrawn right after acceptance.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_FAST = 2'd1,
        RSP_SLOW = 2'd2,
        RSP_MISS = 2'd3
    } rsp_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRED,
        ST_ALT,
        ST_FILL,
        ST_RESP
    } ctl_state_e;

    // Response kind reported from a given controller state.
    function automatic rsp_kind_e kind_of(ctl_state_e s);
        case (s)
            ST_PRED: return RSP_FAST;
            ST_ALT:  return RSP_SLOW;
            ST_RESP: return RSP_MISS;
            default: return RSP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wpc_way.sv
module wpc_way #(
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(SETS)-1:0]    rd_idx,
    input  logic [$clog2(WORDS)-1:0]   rd_off,
    output logic [TAG_W-1:0]           rd_tag,
    output logic                       rd_valid,
    output logic [DATA_W-1:0]          rd_data,
    input  logic                       wr_en,
    input  logic [$clog2(SETS)-1:0]    wr_idx,
    input  logic [$clog2(WORDS)-1:0]   wr_off,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       tag_en,
    input  logic [TAG_W-1:0]           wr_tag
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] word_q [SETS][WORDS];

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_data  = word_q[rd_idx][rd_off];

    // Valid bit and tag are written together on the final refill beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (tag_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (tag_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[wr_idx][wr_off] <= wr_data;
        end
    end
endmodule

// File: rtl/wpc_pred.sv
module wpc_pred #(
    parameter int SETS = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(SETS)-1:0] rd_idx,
    output logic                    pred_o,
    output logic                    lru_o,
    input  logic                    upd_en,
    input  logic [$clog2(SETS)-1:0] upd_idx,
    input  logic                    upd_way
);
    logic [SETS-1:0] pred_q;
    logic [SETS-1:0] lru_q;

    assign pred_o = pred_q[rd_idx];
    assign lru_o  = lru_q[rd_idx];

    // The way just used becomes the guess; the other one becomes the victim.
    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
            lru_q  <= '0;
        end else if (upd_en) begin
            pred_q[upd_idx] <= upd_way;
            lru_q[upd_idx]  <= ~upd_way;
        end
    end
endmodule

// File: rtl/wp_cache.sv
module wp_cache
    import wpc_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_kind,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int OFF_W = $clog2(WORDS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } addr_t;

    ctl_state_e       state;
    addr_t            q;
    logic             victim_q;
    logic [OFF_W-1:0] beat;

    logic pred_o, lru_o, rd_way, hit_sel, upd_en, fill_beat, fill_last;
    logic [TAG_W-1:0]  way_tag   [NUM_WAYS];
    logic              way_valid [NUM_WAYS];
    logic [DATA_W-1:0] way_data  [NUM_WAYS];

    // Way steering: the guessed way first, then the other one, then the refill victim.
    always_comb begin
        case (state)
            ST_PRED: rd_way = pred_o;
            ST_ALT:  rd_way = ~pred_o;
            default: rd_way = victim_q;
        endcase
    end

    assign hit_sel   = way_valid[rd_way] && (way_tag[rd_way] == q.tag);
    assign fill_beat = (state == ST_FILL) && mem_rsp_valid;
    assign fill_last = fill_beat && (beat == LAST_BEAT);

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        wpc_way #(
            .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
        ) u_way (
            .clk      (clk),
            .rst      (rst),
            .rd_idx   (q.idx),
            .rd_off   (q.off),
            .rd_tag   (way_tag[g]),
            .rd_valid (way_valid[g]),
            .rd_data  (way_data[g]),
            .wr_en    (fill_beat && (victim_q == 1'(g))),
            .wr_idx   (q.idx),
            .wr_off   (beat),
            .wr_data  (mem_rsp_data),
            .tag_en   (fill_last && (victim_q == 1'(g))),
            .wr_tag   (q.tag)
        );
    end

    assign upd_en = (((state == ST_PRED) || (state == ST_ALT)) && hit_sel) || fill_last;

    wpc_pred #(.SETS(SETS)) u_pred (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (q.idx),
        .pred_o  (pred_o),
        .lru_o   (lru_o),
        .upd_en  (upd_en),
        .upd_idx (q.idx),
        .upd_way (rd_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            mem_req_valid <= 1'b0;
            beat          <= '0;
            victim_q      <= 1'b0;
            q             <= '0;
        end else begin
            mem_req_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        q     <= addr_t'(req_addr);
                        state <= ST_PRED;
                    end
                end
                ST_PRED: state <= hit_sel ? ST_IDLE : ST_ALT;
                ST_ALT: begin
                    if (hit_sel) begin
                        state <= ST_IDLE;
                    end else begin
                        victim_q      <= lru_o;
                        mem_req_valid <= 1'b1;
                        beat          <= '0;
                        state         <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_rsp_valid) begin
                        beat <= beat + 1'b1;
                        if (beat == LAST_BEAT) state <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (state == ST_IDLE);
    assign rsp_valid    = (((state == ST_PRED) || (state == ST_ALT)) && hit_sel) || (state == ST_RESP);
    assign rsp_kind     = rsp_valid ? kind_of(state) : RSP_NONE;
    assign rsp_data     = way_data[rd_way];
    assign mem_req_addr = {q.tag, q.idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/wp_cache_chk.sv
module wp_cache_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic [1:0] rsp_kind,
    input logic       mem_req_valid,
    input logic       mem_rsp_valid
);
    assert_accept_drops_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_rsp_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    assert_kind_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_kind == 2'd0));

    assert_kind_present_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_kind != 2'd0));

    assert_fast_follows_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd1) |-> $past(req_valid && req_ready));

    assert_no_slow_first_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !(rsp_valid && rsp_kind == 2'd2));

    assert_miss_after_last_beat_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd3) |-> $past(mem_rsp_valid));

    assert_mem_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    assert_mem_req_busy_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (!req_ready && !rsp_valid));
endmodule

bind wp_cache wp_cache_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_kind      (rsp_kind),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/wp_cache_test.sv
module wp_cache_test;
    localparam int SETS = 16;
    localparam int WORDS = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [1:0] rsp_kind;
    logic mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int mreq_cnt = 0;
    logic [ADDR_W-1:0] maddr = '0;
    bit done = 0;

    // Behavioural reference state
    int mtag [SETS][2];
    bit mval [SETS][2];
    int mpred [SETS];
    int mlru [SETS];

    always #4 clk = ~clk;

    wp_cache #(.SETS(SETS), .WORDS(WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_kind(rsp_kind),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [DATA_W-1:0] memword(input logic [ADDR_W-1:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h00C0FFEE;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model: two idle cycles after a pulse, then WORDS back-to-back beats.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                mreq_cnt++;
                maddr = mem_req_addr;
                repeat (2) @(negedge clk);
                for (int b = 0; b < WORDS; b++) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = memword(maddr + ADDR_W'(b));
                    @(negedge clk);
                end
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic do_req(input logic [ADDR_W-1:0] a, input int want);
        int idx, tg, hw, ek, n, base;
        bit busy_ok;
        idx = int'(a[5:2]);
        tg  = int'(a[15:6]);
        hw  = -1;
        for (int w = 0; w < 2; w++)
            if (mval[idx][w] && mtag[idx][w] == tg) hw = w;
        if (hw == mpred[idx]) ek = 1;
        else if (hw >= 0) ek = 2;
        else ek = 3;

        while (!req_ready) @(negedge clk);
        base = mreq_cnt;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        busy_ok = 1;
        while (!rsp_valid && n < 500) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            n++;
        end
        if (req_ready || !rsp_valid) busy_ok = 0;

        if (ek == 1) begin
            chk(rsp_kind == 2'd1, "R2", "fast kind", rsp_kind, ek);
            chk(n == 1, "R2", "fast latency", n, 1);
            chk(rsp_data == memword(a), "R7", "fast data", rsp_data, memword(a));
        end else if (ek == 2) begin
            chk(rsp_kind == 2'd2, "R3", "slow kind", rsp_kind, ek);
            chk(n == 2, "R3", "slow latency", n, 2);
            chk(rsp_data == memword(a), "R7", "slow data", rsp_data, memword(a));
        end else begin
            chk(rsp_kind == 2'd3, "R4", "miss kind", rsp_kind, ek);
            chk(n >= 3, "R4", "miss latency", n, 3);
            chk(rsp_data == memword(a), "R4", "miss data", rsp_data, memword(a));
            chk(maddr == {a[15:2], 2'b00}, "R4", "refill address", maddr, {a[15:2], 2'b00});
        end
        chk(mreq_cnt - base == (ek == 3 ? 1 : 0), "R8", "refill request count",
            mreq_cnt - base, (ek == 3 ? 1 : 0));
        chk(busy_ok, "R6", "ready low while busy", busy_ok, 1);
        if (want != 0) chk(rsp_kind == 2'(want), "R5", "directed kind", rsp_kind, want);

        if (ek == 3) begin
            hw = mlru[idx];
            mval[idx][hw] = 1;
            mtag[idx][hw] = tg;
        end
        mpred[idx] = hw;
        mlru[idx]  = 1 - hw;
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tg, input int idx, input int off);
        return {10'(tg), 4'(idx), 2'(off)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            mval[s][0] = 0; mval[s][1] = 0;
            mtag[s][0] = 0; mtag[s][1] = 0;
            mpred[s] = 0; mlru[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1", "no refill after reset", mem_req_valid, 0);

        // R1: cold access misses; R2: repeat and same-block words hit fast
        do_req(mk(5, 0, 1), 3);
        do_req(mk(5, 0, 1), 1);
        do_req(mk(5, 0, 3), 1);
        do_req(mk(5, 0, 0), 1);

        // R5/R3: conflict sequence in set 3
        do_req(mk(1, 3, 0), 3);   // way0
        do_req(mk(2, 3, 2), 3);   // way1, guess way1
        do_req(mk(1, 3, 1), 2);   // slow, retrain to way0
        do_req(mk(1, 3, 1), 1);   // R3 retrained guess
        do_req(mk(3, 3, 0), 3);   // evicts tag 2 from way1
        do_req(mk(2, 3, 0), 3);   // tag 2 gone; evicts way0 (tag 1)
        do_req(mk(3, 3, 3), 2);   // tag 3 still in way1
        do_req(mk(1, 3, 2), 3);   // tag 1 was evicted

        // Mixed traffic over two sets and four tags
        for (int i = 0; i < 400; i++) begin
            do_req(mk(1 + int'($urandom_range(3)), int'($urandom_range(1)) + 8,
                      int'($urandom_range(3))), 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule